// File: doc/BRIEF.md
# Sponge Hash Sequencer with State Stack

This block sequences a ternary sponge hash around an external multi-cycle permutation engine. A host loads a 243-trit input block into a holding register and issues commands. A start command absorbs the block into the sponge state and fires the engine. It can then absorb an extra padding block and repeat the whole hash a programmed number of times, feeding each digest back in as the next input without any new host data. The digest is the rate part of the state after the final permutation.

The engine is reached through a start/done port pair. The sequencer presents the full state, raises a one-cycle start, and waits for done before it takes the permuted state back. A small stack of complete sponge states lets software push the running hash aside, compute another one on the same engine, and pop the first one back to resume it. The sponge state has 729 trits and the rate is its first 243 trits. Each trit is a 2-bit code: 00 is 0, 01 is +1, 10 is -1. Trit i sits at bits [2i+1:2i], so the rate occupies the low 486 bits of the state.

Top module: `sponge_seq`

## Requirements
- R1: After reset, `busy`, `stk_ovf`, `stk_unf` and `perm_start` are 0, `stk_depth` is 0, and the state shown on `perm_state_out` is all zero.
- R2: A start command (`cmd_op` = 1) replaces the rate trits of the state with the held block and keeps the capacity trits. It then runs one permutation. Without padding, `digest` equals the rate of the permuted state.
- R3: With `cfg_pad` = 1 at start, each absorbed block is followed by a second permutation of a padding block. The padding block has trit 0 = +1 (code 01) and every other rate trit 0 (code 00).
- R4: `cfg_loops` = N runs N hashes, and `cfg_loops` = 0 runs one hash. From the second iteration onwards, the capacity is cleared and the previous digest is absorbed as the input.
- R5: When padding is enabled, the padding block is absorbed in every loop iteration.
- R6: `perm_start` is a one-cycle pulse. It is never raised again before `perm_done` answers the previous start. Each hash issues exactly one permutation per absorbed block.
- R7: `busy` is high from the cycle after start until the last iteration has finished. While `busy` is high, every command and every block write is ignored.
- R8: Push (`cmd_op` = 2) copies the state onto the stack and increments `stk_depth`. Pop (`cmd_op` = 3) restores the most recently pushed state and decrements `stk_depth`, in last-in first-out order.
- R9: A push when the stack holds `STACK_DEPTH` entries sets the sticky `stk_ovf`. The depth and the state stay unchanged.
- R10: A pop with an empty stack sets the sticky `stk_unf` and leaves the state unchanged.
- R11: A zero command (`cmd_op` = 4) clears the state. A flag-clear command (`cmd_op` = 5) clears `stk_ovf` and `stk_unf`, which otherwise stay set. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_we | input | 1 | Write `blk_wdata` into the input block register |
| blk_wdata | input | 486 | Input block, 243 trits |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 start, 2 push, 3 pop, 4 zero, 5 flag clear) |
| cfg_pad | input | 1 | Enable the padding block, sampled at start |
| cfg_loops | input | 8 | Number of hash iterations, sampled at start |
| perm_start | output | 1 | Start pulse to the permutation engine |
| perm_state_out | output | 1458 | Current sponge state, the input to the engine |
| perm_done | input | 1 | Engine finished |
| perm_state_in | input | 1458 | Permuted state from the engine |
| busy | output | 1 | Hash sequence in progress |
| digest | output | 486 | Rate of the state after the last permutation |
| stk_depth | output | 3 | Number of stacked states |
| stk_ovf | output | 1 | Sticky push-when-full flag |
| stk_unf | output | 1 | Sticky pop-when-empty flag |

## Verification
The assertions watch the engine handshake on every cycle: single-cycle start pulses, no restart before done, and busy held while a permutation is outstanding. They also check that commands leave the stack depth alone while busy, that the overflow and underflow cases keep the state and set their flags, and that the flags stay sticky. Only the bench's scenarios can show the following: the digest values for the different padding and loop settings, with loop counts of zero and above one; the exact number of permutations per hash; the last-in first-out order of restored states; and that a block written during a hash does not reach the result.

// File: rtl/sponge_seq_pkg.sv
package sponge_seq_pkg;
   localparam int TRIT_W = 2;
   localparam logic [1:0] TRIT_ZERO = 2'b00;
   localparam logic [1:0] TRIT_POS  = 2'b01;
   localparam logic [1:0] TRIT_NEG  = 2'b10;

   localparam logic [2:0] OP_NONE  = 3'd0;
   localparam logic [2:0] OP_START = 3'd1;
   localparam logic [2:0] OP_PUSH  = 3'd2;
   localparam logic [2:0] OP_POP   = 3'd3;
   localparam logic [2:0] OP_ZERO  = 3'd4;
   localparam logic [2:0] OP_FCLR  = 3'd5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD,
      PH_KICK,
      PH_WAIT,
      PH_PAD,
      PH_SQZ
   } phase_e;
endpackage

// File: rtl/sponge_pad_gen.sv
module sponge_pad_gen
   import sponge_seq_pkg::*;
#(
   parameter int RATE_TRITS = 243,
   localparam int RATE_W = RATE_TRITS * TRIT_W
) (
   output logic [RATE_W-1:0] pad_blk
);
   for (genvar g = 0; g < RATE_TRITS; g++) begin : g_trit
      if (g == 0) begin : g_lead
         assign pad_blk[g*TRIT_W +: TRIT_W] = TRIT_POS;
      end else begin : g_fill
         assign pad_blk[g*TRIT_W +: TRIT_W] = TRIT_ZERO;
      end
   end
endmodule

// File: rtl/sponge_loop_ctr.sv
module sponge_loop_ctr #(
   parameter int LOOP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LOOP_W-1:0] load_val,
   input  logic              dec,
   output logic              last
);
   logic [LOOP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_val == '0) ? LOOP_W'(1) : load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - LOOP_W'(1);
      end
   end

   assign last = (cnt_q <= LOOP_W'(1));
endmodule

// File: rtl/sponge_state_stack.sv
module sponge_state_stack #(
   parameter int ENTRY_W = 1458,
   parameter int DEPTH   = 4,
   localparam int PTR_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_req,
   input  logic               pop_req,
   input  logic               flag_clr,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] rdata,
   output logic               pop_ok,
   output logic [PTR_W-1:0]   depth,
   output logic               ovf,
   output logic               unf
);
   logic [PTR_W-1:0] ptr_q;
   logic             full, empty, push_ok;
   logic             ovf_q, unf_q;
   logic [DEPTH-1:0][ENTRY_W-1:0] ents;

   assign full    = (ptr_q == PTR_W'(DEPTH));
   assign empty   = (ptr_q == '0);
   assign push_ok = push_req && !full;
   assign pop_ok  = pop_req && !empty;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [ENTRY_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (push_ok && ptr_q == PTR_W'(g)) begin
            ent_q <= wdata;
         end
      end
      assign ents[g] = ent_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ptr_q == PTR_W'(i + 1)) begin
            rdata = ents[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         if (push_ok) begin
            ptr_q <= ptr_q + PTR_W'(1);
         end else if (pop_ok) begin
            ptr_q <= ptr_q - PTR_W'(1);
         end
         if (flag_clr) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
         end else begin
            if (push_req && full) ovf_q <= 1'b1;
            if (pop_req && empty) unf_q <= 1'b1;
         end
      end
   end

   assign depth = ptr_q;
   assign ovf   = ovf_q;
   assign unf   = unf_q;
endmodule

// File: rtl/sponge_seq.sv
module sponge_seq
   import sponge_seq_pkg::*;
#(
   parameter int RATE_TRITS  = 243,
   parameter int STATE_TRITS = 729,
   parameter int STACK_DEPTH = 4,
   parameter int LOOP_W      = 8,
   localparam int RATE_W  = RATE_TRITS * TRIT_W,
   localparam int STATE_W = STATE_TRITS * TRIT_W,
   localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blk_we,
   input  logic [RATE_W-1:0]  blk_wdata,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic               cfg_pad,
   input  logic [LOOP_W-1:0]  cfg_loops,
   output logic               perm_start,
   output logic [STATE_W-1:0] perm_state_out,
   input  logic               perm_done,
   input  logic [STATE_W-1:0] perm_state_in,
   output logic               busy,
   output logic [RATE_W-1:0]  digest,
   output logic [DEPTH_W-1:0] stk_depth,
   output logic               stk_ovf,
   output logic               stk_unf
);
   localparam int CAP_W = STATE_W - RATE_W;

   if (STATE_TRITS <= RATE_TRITS) begin : g_bad_rate
      initial $fatal(1, "sponge_seq: state must be wider than the rate");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      initial $fatal(1, "sponge_seq: stack needs at least one entry");
   end
   if (LOOP_W < 1) begin : g_bad_loop
      initial $fatal(1, "sponge_seq: loop counter needs at least one bit");
   end

   phase_e             phase_q;
   logic [STATE_W-1:0] st_q;
   logic [RATE_W-1:0]  blk_q;
   logic [RATE_W-1:0]  dig_q;
   logic               pad_q;
   logic               pad_done_q;

   logic               idle;
   logic               cmd_ok;
   logic               cmd_start, cmd_push, cmd_pop, cmd_zero, cmd_fclr;
   logic [RATE_W-1:0]  pad_blk;
   logic [STATE_W-1:0] stk_rdata;
   logic               pop_ok;
   logic               loop_last;
   logic               loop_dec;

   assign idle      = (phase_q == PH_IDLE);
   assign cmd_ok    = cmd_valid && idle;
   assign cmd_start = cmd_ok && (cmd_op == OP_START);
   assign cmd_push  = cmd_ok && (cmd_op == OP_PUSH);
   assign cmd_pop   = cmd_ok && (cmd_op == OP_POP);
   assign cmd_zero  = cmd_ok && (cmd_op == OP_ZERO);
   assign cmd_fclr  = cmd_ok && (cmd_op == OP_FCLR);
   assign loop_dec  = (phase_q == PH_SQZ);

   sponge_pad_gen #(
      .RATE_TRITS(RATE_TRITS)
   ) u_pad (
      .pad_blk(pad_blk)
   );

   sponge_loop_ctr #(
      .LOOP_W(LOOP_W)
   ) u_loop (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_start),
      .load_val(cfg_loops),
      .dec     (loop_dec),
      .last    (loop_last)
   );

   sponge_state_stack #(
      .ENTRY_W(STATE_W),
      .DEPTH  (STACK_DEPTH)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_req(cmd_push),
      .pop_req (cmd_pop),
      .flag_clr(cmd_fclr),
      .wdata   (st_q),
      .rdata   (stk_rdata),
      .pop_ok  (pop_ok),
      .depth   (stk_depth),
      .ovf     (stk_ovf),
      .unf     (stk_unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         st_q       <= '0;
         blk_q      <= '0;
         dig_q      <= '0;
         pad_q      <= 1'b0;
         pad_done_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (blk_we) begin
                  blk_q <= blk_wdata;
               end
               if (cmd_start) begin
                  pad_q   <= cfg_pad;
                  phase_q <= PH_LOAD;
               end else if (cmd_zero) begin
                  st_q <= '0;
               end else if (pop_ok) begin
                  st_q <= stk_rdata;
               end
            end
            PH_LOAD: begin
               st_q[RATE_W-1:0] <= blk_q;
               pad_done_q       <= 1'b0;
               phase_q          <= PH_KICK;
            end
            PH_KICK: begin
               phase_q <= PH_WAIT;
            end
            PH_WAIT: begin
               if (perm_done) begin
                  st_q    <= perm_state_in;
                  phase_q <= (pad_q && !pad_done_q) ? PH_PAD : PH_SQZ;
               end
            end
            PH_PAD: begin
               st_q[RATE_W-1:0] <= pad_blk;
               pad_done_q       <= 1'b1;
               phase_q          <= PH_KICK;
            end
            PH_SQZ: begin
               dig_q <= st_q[RATE_W-1:0];
               if (loop_last) begin
                  phase_q <= PH_IDLE;
               end else begin
                  st_q       <= {{CAP_W{1'b0}}, st_q[RATE_W-1:0]};
                  pad_done_q <= 1'b0;
                  phase_q    <= PH_KICK;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign perm_start     = (phase_q == PH_KICK);
   assign perm_state_out = st_q;
   assign busy           = !idle;
   assign digest         = dig_q;
endmodule

// File: rtl/sponge_seq_chk.sv
module sponge_seq_chk
   import sponge_seq_pkg::*;
#(
   parameter int STATE_W     = 1458,
   parameter int STACK_DEPTH = 4,
   localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [2:0]         cmd_op,
   input logic               busy,
   input logic               perm_start,
   input logic               perm_done,
   input logic [STATE_W-1:0] perm_state_out,
   input logic [DEPTH_W-1:0] stk_depth,
   input logic               stk_ovf,
   input logic               stk_unf
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (perm_start) begin
         pend_q <= 1'b1;
      end else if (perm_done) begin
         pend_q <= 1'b0;
      end
   end

   // R6
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perm_start |=> !perm_start);

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perm_start |-> !pend_q);

   // R7
   busy_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> busy);

   // R7
   busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> (stk_depth == $past(stk_depth)));

   // R8
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_depth <= DEPTH_W'(STACK_DEPTH));

   // R9
   push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_op == OP_PUSH && stk_depth == DEPTH_W'(STACK_DEPTH))
      |=> (stk_ovf && stk_depth == DEPTH_W'(STACK_DEPTH)
           && perm_state_out == $past(perm_state_out)));

   // R10
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_op == OP_POP && stk_depth == '0)
      |=> (stk_unf && stk_depth == '0 && perm_state_out == $past(perm_state_out)));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_ovf && !(cmd_valid && !busy && cmd_op == OP_FCLR)) |=> stk_ovf);

   // R11
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_unf && !(cmd_valid && !busy && cmd_op == OP_FCLR)) |=> stk_unf);
endmodule

bind sponge_seq sponge_seq_chk #(
   .STATE_W    (STATE_W),
   .STACK_DEPTH(STACK_DEPTH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_op        (cmd_op),
   .busy          (busy),
   .perm_start    (perm_start),
   .perm_done     (perm_done),
   .perm_state_out(perm_state_out),
   .stk_depth     (stk_depth),
   .stk_ovf       (stk_ovf),
   .stk_unf       (stk_unf)
);

// File: tb/tb_sponge_seq.sv
`timescale 1ns/1ps
module tb_sponge_seq;
   localparam int RT = 243;
   localparam int ST = 729;
   localparam int RW = RT * 2;
   localparam int SW = ST * 2;
   localparam int DEP = 4;
   localparam int ENG_LAT = 55;

   // columns: pad, loops, block seed
   localparam int NVEC = 6;
   localparam int VEC [NVEC][3] = '{
      '{0, 1, 5}, '{1, 1, 7}, '{0, 3, 11}, '{1, 3, 2}, '{1, 0, 13}, '{0, 2, 4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          blk_we = 1'b0;
   logic [RW-1:0] blk_wdata = '0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic          cfg_pad = 1'b0;
   logic [7:0]    cfg_loops = 8'd1;
   logic          perm_start;
   logic [SW-1:0] perm_state_out;
   logic          perm_done;
   logic [SW-1:0] perm_state_in;
   logic          busy;
   logic [RW-1:0] digest;
   logic [2:0]    stk_depth;
   logic          stk_ovf, stk_unf;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   sponge_seq dut (
      .clk(clk), .rst_n(rst_n), .blk_we(blk_we), .blk_wdata(blk_wdata),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cfg_pad(cfg_pad), .cfg_loops(cfg_loops),
      .perm_start(perm_start), .perm_state_out(perm_state_out), .perm_done(perm_done),
      .perm_state_in(perm_state_in), .busy(busy), .digest(digest),
      .stk_depth(stk_depth), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
   );

   function automatic logic [SW-1:0] perm_f(input logic [SW-1:0] s);
      logic [SW-1:0] r;
      r = {s[SW-3:0], s[SW-1:SW-2]};
      r[1:0] = {r[0], r[1]};
      return r;
   endfunction

   function automatic logic [RW-1:0] mk_blk(input int seed);
      logic [RW-1:0] b;
      for (int i = 0; i < RT; i++) begin
         int v;
         v = (i * seed + i / 5 + seed) % 3;
         b[2*i +: 2] = (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : 2'b10;
      end
      return b;
   endfunction

   // stand-in permutation engine
   int            eng_cnt;
   int            eng_starts;
   int            eng_overlap;
   logic [SW-1:0] eng_res;
   assign perm_state_in = eng_res;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_cnt <= 0; eng_starts <= 0; eng_overlap <= 0;
         eng_res <= '0; perm_done <= 1'b0;
      end else begin
         perm_done <= 1'b0;
         if (perm_start) begin
            eng_starts <= eng_starts + 1;
            if (eng_cnt != 0) eng_overlap <= eng_overlap + 1;
            eng_res <= perm_f(perm_state_out);
            eng_cnt <= ENG_LAT;
         end else if (eng_cnt != 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) perm_done <= 1'b1;
         end
      end
   end

   logic [SW-1:0] exp_st = '0;
   logic [RW-1:0] exp_blk = '0;
   logic [RW-1:0] pad_ref;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_w(input bit ok, input string req, input string what,
                        input logic [SW-1:0] act, input logic [SW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic load_blk(input logic [RW-1:0] b);
      @(negedge clk);
      blk_we = 1'b1; blk_wdata = b;
      @(negedge clk);
      blk_we = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic model(input bit pad, input int loops);
      logic [SW-1:0] s;
      logic [RW-1:0] b;
      int n;
      s = exp_st; b = exp_blk;
      n = (loops == 0) ? 1 : loops;
      for (int i = 0; i < n; i++) begin
         if (i > 0) s = '0;
         s[RW-1:0] = b;
         s = perm_f(s);
         if (pad) begin
            s[RW-1:0] = pad_ref;
            s = perm_f(s);
         end
         b = s[RW-1:0];
      end
      exp_st = s;
   endtask

   task automatic run_hash(input bit pad, input int loops, input string req);
      int s0, n;
      s0 = eng_starts;
      n = (loops == 0) ? 1 : loops;
      cfg_pad = pad; cfg_loops = 8'(loops);
      do_cmd(3'd1);
      chk(busy == 1'b1, "R7", "busy after start", busy, 1);
      wait_idle();
      model(pad, loops);
      chk_w(digest == exp_st[RW-1:0], req, "digest", SW'(digest), SW'(exp_st[RW-1:0]));
      chk_w(perm_state_out == exp_st, req, "final state", perm_state_out, exp_st);
      chk(eng_starts - s0 == n * (pad ? 2 : 1), "R6", "permutation count",
          eng_starts - s0, n * (pad ? 2 : 1));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [SW-1:0] saved;
      pad_ref = '0;
      pad_ref[1:0] = 2'b01;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(stk_depth == 3'd0, "R1", "depth", stk_depth, 0);
      chk(stk_ovf == 1'b0 && stk_unf == 1'b0, "R1", "flags", {stk_ovf, stk_unf}, 0);
      chk(perm_start == 1'b0, "R1", "perm_start", perm_start, 0);
      chk_w(perm_state_out == '0, "R1", "state", perm_state_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R2 plain, R3 padded, R4 looped, R5 padded loops
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         exp_blk = mk_blk(VEC[v][2]);
         load_blk(exp_blk);
         if (VEC[v][0] != 0 && VEC[v][1] > 1) tag = "R5";
         else if (VEC[v][1] != 1) tag = "R4";
         else if (VEC[v][0] != 0) tag = "R3";
         else tag = "R2";
         run_hash(VEC[v][0] != 0, VEC[v][1], tag);
      end
      chk(eng_overlap == 0, "R6", "start while engine active", eng_overlap, 0);

      // R8 push, nested hash, pop restores
      saved = exp_st;
      do_cmd(3'd2);
      chk(stk_depth == 3'd1, "R8", "depth after push", stk_depth, 1);
      do_cmd(3'd4);
      chk_w(perm_state_out == '0, "R11", "zero command", perm_state_out, '0);
      exp_st = '0;
      exp_blk = mk_blk(17);
      load_blk(exp_blk);
      run_hash(1'b1, 2, "R8");
      do_cmd(3'd3);
      chk_w(perm_state_out == saved, "R8", "pop restores", perm_state_out, saved);
      chk(stk_depth == 3'd0, "R8", "depth after pop", stk_depth, 0);
      exp_st = saved;

      // R10 pop when empty
      do_cmd(3'd3);
      chk(stk_unf == 1'b1, "R10", "underflow flag", stk_unf, 1);
      chk_w(perm_state_out == saved, "R10", "state kept", perm_state_out, saved);
      do_cmd(3'd0);
      chk(stk_unf == 1'b1, "R11", "underflow sticky", stk_unf, 1);
      do_cmd(3'd5);
      chk(stk_unf == 1'b0, "R11", "flag clear", stk_unf, 0);

      // R9 fill, overflow, LIFO unwind
      do_cmd(3'd2);
      do_cmd(3'd4);
      for (int k = 0; k < DEP - 1; k++) do_cmd(3'd2);
      chk(stk_depth == 3'(DEP), "R8", "depth full", stk_depth, DEP);
      do_cmd(3'd2);
      chk(stk_ovf == 1'b1, "R9", "overflow flag", stk_ovf, 1);
      chk(stk_depth == 3'(DEP), "R9", "depth kept", stk_depth, DEP);
      chk_w(perm_state_out == '0, "R9", "state kept", perm_state_out, '0);
      for (int k = 0; k < DEP - 1; k++) do_cmd(3'd3);
      chk_w(perm_state_out == '0, "R8", "inner entries", perm_state_out, '0);
      do_cmd(3'd3);
      chk_w(perm_state_out == saved, "R8", "LIFO bottom entry", perm_state_out, saved);
      chk(stk_ovf == 1'b1, "R11", "overflow sticky", stk_ovf, 1);
      do_cmd(3'd5);
      chk(stk_ovf == 1'b0, "R11", "overflow cleared", stk_ovf, 0);

      // R7 commands and block writes while busy are ignored
      begin
         int s0;
         s0 = eng_starts;
         exp_blk = mk_blk(23);
         load_blk(exp_blk);
         cfg_pad = 1'b1; cfg_loops = 8'd2;
         do_cmd(3'd1);
         repeat (5) @(negedge clk);
         chk(busy == 1'b1, "R7", "busy mid-hash", busy, 1);
         do_cmd(3'd2);
         do_cmd(3'd4);
         do_cmd(3'd3);
         do_cmd(3'd1);
         load_blk(mk_blk(29));
         wait_idle();
         model(1'b1, 2);
         chk(stk_depth == 3'd0 && stk_unf == 1'b0, "R7", "stack untouched",
             {stk_depth, stk_unf}, 0);
         chk_w(perm_state_out == exp_st, "R7", "state unaffected", perm_state_out, exp_st);
         chk(eng_starts - s0 == 4, "R7", "no extra start", eng_starts - s0, 4);
         run_hash(1'b0, 1, "R7");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule